// File: doc/BRIEF.md
# PLL Control Register with Lock Timer

This block is the software-visible control and status word for a clock generator's PLL. Software writes three frequency-setting fields: a 2-bit post-scaler, a 6-bit main divider and a 6-bit pre-divider. It also writes a bit that selects whether the divided clocks come from the oscillator or from the PLL, and a bit that decides whether the crystal stays powered during power down. The field values drive the analog PLL and the clock muxes directly.

Hardware fills in a read-only lock flag. The flag does not come from a phase detector. A counter runs on the oscillator clock and reports lock after a fixed number of oscillator cycles outside standby. Three things clear the flag and restart the count: a standby level from the separate clock-control register, a write that changes any frequency field, and release from reset. The flag crosses into the bus clock through a two-flop synchronizer. A request/acknowledge handshake keeps the flag hidden until the oscillator side has really restarted.

Top module: `pll_ctrl_reg`

## Requirements
- R1: The read word places the lock flag at bit 20, the crystal power-down enable at bit 19, the divided-clock source select at bit 18, the post-scaler at bits 17:16, the main divider at bits 13:8 and the pre-divider at bits 5:0. Bits 31:21, 15:14 and 7:6 read as zero.
- R2: After reset the word reads 0x00002E0E: main divider 0x2E, pre-divider 0x0E, every other field 0.
- R3: Write data in the reserved bits and in bit 20 is discarded and never appears in the read word.
- R4: Once standby is released, the lock flag reads 1 only after LOCK_CYCLES (default 4096) oscillator cycles, plus the synchronizer latency. It reads 0 before that.
- R5: While standby is 1, the lock flag reads 0 from the next bus cycle. Releasing standby restarts the count from zero.
- R6: The lock counter saturates, so once set the flag stays 1 for as long as standby stays low and no frequency field changes.
- R7: A write that changes the post-scaler, main divider or pre-divider makes the lock flag read 0 from the cycle after the write. The full count then restarts. A write that leaves these three fields unchanged does not disturb the flag.
- R8: Output `div_src_pll` follows bit 18. A value of 0 selects the oscillator as source of the divided clocks and 1 selects the PLL output.
- R9: `xtal_pd_en` is 1 whenever `pd_xtal_ctl` is 0. When `pd_xtal_ctl` is 1, `xtal_pd_en` is 0 if bit 19 is 0 and equals `ckctrl_xtal` if bit 19 is 1.
- R10: Outputs `pll_s`, `pll_m` and `pll_p` equal the stored post-scaler, main divider and pre-divider fields. They change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| osc_clk | input | 1 | Oscillator clock for the lock timer |
| osc_rst_n | input | 1 | Oscillator-domain reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Combinational read of the register word |
| pll_standby | input | 1 | PLL standby level from the clock-control register (bus domain) |
| pd_xtal_ctl | input | 1 | External power-down control bit that gates bit 19 |
| ckctrl_xtal | input | 1 | Crystal bit of the clock-control register |
| pll_s | output | 2 | Post-scaler to the PLL |
| pll_m | output | 6 | Main divider to the PLL |
| pll_p | output | 6 | Pre-divider to the PLL |
| div_src_pll | output | 1 | Divided-clock source: 0 oscillator, 1 PLL |
| xtal_pd_en | output | 1 | Crystal stays enabled during power down |

## Verification
A stuck or miscounted lock counter shows up only on bit 20, either thousands of oscillator cycles too early or too late. The bench therefore brackets the expected lock time with samples shortly before and shortly after it. A lost restart handshake shows as the flag staying 1 across a divider change. That is visible on the very next bus cycle, because the stale mask must drop the flag immediately. A field-masking error appears in the read word on the cycle after the offending write.

// File: rtl/pllctl_pkg.sv
`timescale 1ns/1ps
package pllctl_pkg;

    localparam int REG_W    = 32;
    localparam int S_W      = 2;
    localparam int M_W      = 6;
    localparam int P_W      = 6;
    localparam int LOCK_BIT = 20;
    localparam int XTE_BIT  = 19;
    localparam int DSEL_BIT = 18;
    localparam int S_LSB    = 16;
    localparam int M_LSB    = 8;
    localparam int P_LSB    = 0;

    typedef struct packed {
        logic           xte;
        logic           dsel;
        logic [S_W-1:0] s;
        logic [M_W-1:0] m;
        logic [P_W-1:0] p;
    } pll_cfg_t;

    function automatic logic [REG_W-1:0] pll_pack(pll_cfg_t c, logic lock);
        logic [REG_W-1:0] w;
        w                 = '0;
        w[LOCK_BIT]       = lock;
        w[XTE_BIT]        = c.xte;
        w[DSEL_BIT]       = c.dsel;
        w[S_LSB +: S_W]   = c.s;
        w[M_LSB +: M_W]   = c.m;
        w[P_LSB +: P_W]   = c.p;
        return w;
    endfunction

endpackage

// File: rtl/pllctl_sync.sv
`timescale 1ns/1ps
module pllctl_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pllctl_lock_timer.sv
`timescale 1ns/1ps
module pllctl_lock_timer #(
    parameter int LOCK_CYCLES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic osc_rst_n,
    input  logic standby_a,     // asynchronous to osc_clk
    input  logic restart_req_a, // asynchronous to osc_clk
    output logic restart_ack,
    output logic lock
);

    localparam int              CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(LOCK_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
        logic             ack;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic stby_s, req_s, clr;

    pllctl_sync #(.STAGES(SYNC_STAGES), .W(2)) i_in_sync (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .d     ({standby_a, restart_req_a}),
        .q     ({stby_s, req_s})
    );

    // Counter is held at zero while standby or a restart handshake is active.
    assign clr = stby_s | req_s;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.ack = req_s;
        if (clr)               tmr_d.cnt = '0;
        else if (tmr_q.cnt != TERM) tmr_d.cnt = tmr_q.cnt + 1'b1;
        tmr_d.lock = !clr && (tmr_d.cnt == TERM);
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) tmr_q <= '0;
        else            tmr_q <= tmr_d;
    end

    assign restart_ack = tmr_q.ack;
    assign lock        = tmr_q.lock;

    AST_LOCK_HOLD: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        (tmr_q.lock && !clr) |=> tmr_q.lock); // R6
    AST_CLR_RESTARTS: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        clr |=> (tmr_q.cnt == '0 && !tmr_q.lock)); // R5
    AST_LOCK_AT_TERM: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        tmr_q.lock |-> (tmr_q.cnt == TERM)); // R4
    AST_CNT_BOUND: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        tmr_q.cnt <= TERM); // R6

endmodule

// File: rtl/pllctl_regs.sv
`timescale 1ns/1ps
module pllctl_regs
    import pllctl_pkg::*;
#(
    parameter logic [M_W-1:0] M_RST = 6'h2E,
    parameter logic [P_W-1:0] P_RST = 6'h0E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             standby,
    input  logic             ack_s,
    input  logic             lock_s,
    output pll_cfg_t         cfg,
    output logic             restart_req,
    output logic [REG_W-1:0] rd_data
);

    typedef struct packed {
        pll_cfg_t cfg;
        logic     req;
        logic     again;
    } regs_t;

    localparam pll_cfg_t CFG_RST = '{xte: 1'b0, dsel: 1'b0, s: '0, m: M_RST, p: P_RST};

    regs_t    r_d, r_q;
    pll_cfg_t wr_cfg;
    logic     smp_change, hs_idle, stale;
    logic     unused_wr_bits;

    always_comb begin
        wr_cfg.xte  = wr_data[XTE_BIT];
        wr_cfg.dsel = wr_data[DSEL_BIT];
        wr_cfg.s    = wr_data[S_LSB +: S_W];
        wr_cfg.m    = wr_data[M_LSB +: M_W];
        wr_cfg.p    = wr_data[P_LSB +: P_W];
    end

    // Reserved bits and the lock bit are accepted on the bus but discarded.
    assign unused_wr_bits = ^{wr_data[REG_W-1:LOCK_BIT], wr_data[15:14], wr_data[7:6]};

    assign smp_change = wr_en && ({wr_cfg.s, wr_cfg.m, wr_cfg.p} !=
                                  {r_q.cfg.s, r_q.cfg.m, r_q.cfg.p});
    assign hs_idle    = !r_q.req && !ack_s;

    always_comb begin
        r_d = r_q;
        if (wr_en) r_d.cfg = wr_cfg;
        if (r_q.req && ack_s) r_d.req = 1'b0;
        if (smp_change) begin
            if (hs_idle) r_d.req   = 1'b1;
            else         r_d.again = 1'b1;
        end else if (hs_idle && r_q.again) begin
            r_d.req   = 1'b1;
            r_d.again = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: CFG_RST, req: 1'b0, again: 1'b0};
        else        r_q <= r_d;
    end

    assign stale       = r_q.req | r_q.again | ack_s;
    assign cfg         = r_q.cfg;
    assign restart_req = r_q.req;
    assign rd_data     = pll_pack(r_q.cfg, lock_s & ~stale & ~standby);

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q.cfg)); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !ack_s) |=> r_q.req); // R7
    AST_PENDING_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req || r_q.again) |-> !rd_data[LOCK_BIT]); // R7
    AST_CHANGE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_change |=> !rd_data[LOCK_BIT]); // R7

endmodule

// File: rtl/pll_ctrl_reg.sv
`timescale 1ns/1ps
module pll_ctrl_reg
    import pllctl_pkg::*;
#(
    parameter int LOCK_CYCLES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_clk,
    input  logic        osc_rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        pll_standby,
    input  logic        pd_xtal_ctl,
    input  logic        ckctrl_xtal,
    output logic [1:0]  pll_s,
    output logic [5:0]  pll_m,
    output logic [5:0]  pll_p,
    output logic        div_src_pll,
    output logic        xtal_pd_en
);

    pll_cfg_t cfg;
    logic     req, ack_o, lock_o, ack_s, lock_s;

    pllctl_regs #(.M_RST(6'h2E), .P_RST(6'h0E)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .standby     (pll_standby),
        .ack_s       (ack_s),
        .lock_s      (lock_s),
        .cfg         (cfg),
        .restart_req (req),
        .rd_data     (rd_data)
    );

    pllctl_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)) i_timer (
        .osc_clk       (osc_clk),
        .osc_rst_n     (osc_rst_n),
        .standby_a     (pll_standby),
        .restart_req_a (req),
        .restart_ack   (ack_o),
        .lock          (lock_o)
    );

    pllctl_sync #(.STAGES(SYNC_STAGES), .W(2)) i_out_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ack_o, lock_o}),
        .q     ({ack_s, lock_s})
    );

    always_comb begin
        pll_s       = cfg.s;
        pll_m       = cfg.m;
        pll_p       = cfg.p;
        div_src_pll = cfg.dsel;
        if (!pd_xtal_ctl)  xtal_pd_en = 1'b1;
        else if (cfg.xte)  xtal_pd_en = ckctrl_xtal;
        else               xtal_pd_en = 1'b0;
    end

    AST_STANDBY_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        pll_standby |-> !rd_data[LOCK_BIT]); // R5
    AST_XTAL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_xtal_ctl |-> xtal_pd_en); // R9
    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:21] == '0) && (rd_data[15:14] == '0) && (rd_data[7:6] == '0)); // R1

endmodule

// File: tb/test_pll_ctrl_reg.sv
`timescale 1ns/1ps
module test_pll_ctrl_reg;

    logic        clk = 1'b0, osc_clk = 1'b0;
    logic        rst_n = 1'b0, osc_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pll_standby = 1'b1, pd_xtal_ctl = 1'b0, ckctrl_xtal = 1'b0;
    logic [1:0]  pll_s;
    logic [5:0]  pll_m, pll_p;
    logic        div_src_pll, xtal_pd_en;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always #6   osc_clk = ~osc_clk;

    pll_ctrl_reg i_pll_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pll_standby(pll_standby), .pd_xtal_ctl(pd_xtal_ctl), .ckctrl_xtal(ckctrl_xtal),
        .pll_s(pll_s), .pll_m(pll_m), .pll_p(pll_p),
        .div_src_pll(div_src_pll), .xtal_pd_en(xtal_pd_en)
    );

    // {write word, expected read word}; standby held, so bit 20 reads 0
    localparam logic [63:0] VEC [6] = '{
        {32'hFFFF_FFFF, 32'h000F_3F3F},
        {32'h0000_0000, 32'h0000_0000},
        {32'h0012_5A1C, 32'h0002_1A1C},
        {32'h0048_0FC7, 32'h0008_0F07},
        {32'h0004_C0C0, 32'h0004_0000},
        {32'h7FE1_AA55, 32'h0001_2A15}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_osc(input int n);
        repeat (n) @(posedge osc_clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1; osc_rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset word", rd_data, 32'h0000_2E0E);
        check("R10 reset outputs", {18'd0, pll_s, pll_m, pll_p}, {18'd0, 2'd0, 6'h2E, 6'h0E});
        check("R8 reset source", {31'd0, div_src_pll}, 32'd0);

        for (int i = 0; i < 6; i++) begin
            reg_write(VEC[i][63:32]);
            check("R1 R3 field masking", rd_data, VEC[i][31:0]);
            check("R10 divider outputs", {18'd0, pll_s, pll_m, pll_p},
                  {18'd0, VEC[i][17:16], VEC[i][13:8], VEC[i][5:0]});
            check("R8 source select", {31'd0, div_src_pll}, {31'd0, VEC[i][18]});
        end

        // R4: lock time after standby release
        reg_write(32'h0000_2E0E);
        @(negedge clk); pll_standby = 1'b0;
        wait_osc(4050);
        check("R4 lock not early", {31'd0, rd_data[20]}, 32'd0);
        wait_osc(60);
        check("R4 lock set", rd_data, 32'h0010_2E0E);
        // R6: saturation
        wait_osc(3000);
        check("R6 lock held", {31'd0, rd_data[20]}, 32'd1);
        // R7: write with unchanged S/M/P keeps lock
        reg_write(32'h0004_2E0E);
        wait_osc(20);
        check("R7 unchanged write keeps lock", rd_data, 32'h0014_2E0E);
        check("R8 pll source", {31'd0, div_src_pll}, 32'd1);
        // R7: divider change drops lock at once and restarts the count
        reg_write(32'h0004_2F0E);
        check("R7 change drops lock", rd_data, 32'h0004_2F0E);
        wait_osc(4050);
        check("R7 no early relock", {31'd0, rd_data[20]}, 32'd0);
        wait_osc(80);
        check("R7 relock", rd_data, 32'h0014_2F0E);
        // R5: standby clears and restarts
        pll_standby = 1'b1;
        @(negedge clk);
        check("R5 standby clears", {31'd0, rd_data[20]}, 32'd0);
        wait_osc(10);
        check("R5 standby held", {31'd0, rd_data[20]}, 32'd0);
        pll_standby = 1'b0;
        wait_osc(4050);
        check("R5 count restarted", {31'd0, rd_data[20]}, 32'd0);
        wait_osc(60);
        check("R5 relock after standby", {31'd0, rd_data[20]}, 32'd1);

        // R9: crystal power-down enable
        reg_write(32'h0000_2F0E);
        pd_xtal_ctl = 1'b0; ckctrl_xtal = 1'b0; @(negedge clk);
        check("R9 ctl0 forces on", {31'd0, xtal_pd_en}, 32'd1);
        pd_xtal_ctl = 1'b1; @(negedge clk);
        check("R9 xte0 off", {31'd0, xtal_pd_en}, 32'd0);
        ckctrl_xtal = 1'b1; @(negedge clk);
        check("R9 xte0 ignores crystal bit", {31'd0, xtal_pd_en}, 32'd0);
        reg_write(32'h0008_2F0E);
        check("R9 xte1 follows 1", {31'd0, xtal_pd_en}, 32'd1);
        ckctrl_xtal = 1'b0; @(negedge clk);
        check("R9 xte1 follows 0", {31'd0, xtal_pd_en}, 32'd0);
        pd_xtal_ctl = 1'b0; @(negedge clk);
        check("R9 ctl0 overrides xte1", {31'd0, xtal_pd_en}, 32'd1);

        finish_run();
    end

endmodule